// File: doc/BRIEF.md
# Broadcast Multiply-Add Bus Slave

This block sits on a synchronous memory bus as a slave and computes one step of a matrix-vector product each time the host writes to it. It has no instruction stream. Every action is chosen by the address the host writes: storing an element, setting the accumulation form, setting the element index, starting a multiply-add, starting a multiply-add that also steps the index, or folding the scalar registers into one sum. The written word on a trigger is always one multiplier operand (A). The other multiplier operand, the addend and the destination come from eight local vector registers and eight local scalar registers. Arithmetic is integer and wraps modulo 2^DataW.

Many instances share one bus, and each has its own segment number. A write to the shared broadcast segment reaches every instance in the same cycle, so a host can load different vectors into each instance and then stream one matrix column through all of them in lockstep. The multiply and the add sit in two pipeline stages. Operands are forwarded between them, so the bus can issue one trigger per cycle and the results match strictly sequential execution.

Top module: `bcast_mac_node`

## Requirements
- R1: The block accepts a write only when address bits [23:20] are 0xF and bits [19:16] equal either its ModId or 0xF (broadcast). Writes to any other address change no state.
- R2: A read of its own segment returns data with busRdValid high one cycle later. A read of the broadcast segment, or of any other address, leaves busRdValid low and busRdData zero.
- R3: Map of offset bits [15:0] within a segment:
  - 0x0000–0x7FFF: vector element, with the register number in bits [14:12] and the element in bits [IdxBits-1:0].
  - 0x8000+k: scalar register k.
  - 0x8010: mode register, with the form code in bits [1:0] and the mirror flag in bit 2.
  - 0x8011: index register.
  - 0x8012: status register, with busy in bit 0.

  Writes to a storage address store the word, and reads return it.
- R4: Form code 0, triggered by a write of A to 0x8020 with index i: S[k] becomes A*V[k][i]+S[k] for k=0..7.
- R5: Form code 1 with index i. With mirror 0, V[4+k][i] becomes A*S[k]+V[k][i] for k=0..3. With mirror 1, V[k][i] becomes A*S[k]+V[4+k][i].
- R6: Form code 2 with index i. With mirror 0, V[4+k][i] becomes A*V[k][i]+S[k] for k=0..3. With mirror 1, V[k][i] becomes A*V[4+k][i]+S[k].
- R7: A write to 0x8021 performs the same operation and then increments the index modulo 2^IdxBits. A write to 0x8020 leaves the index unchanged.
- R8: A write to 0x8022 sets S[0] to the sum of S[0..7] and clears S[1..7].
- R9: Busy reads 1 in the cycle after an accepted trigger or collapse write, and 0 otherwise. Results are visible to a read issued two or more cycles after the write.
- R10: Triggers issued on consecutive cycles give the same storage contents as strictly sequential execution.
- R11: With form code 3, a trigger changes no vector or scalar register.
- R12: Products and sums keep only the low DataW bits.
- R13: After reset, the scalar registers, mode, index and busy all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for this cycle |
| busRdEn | input | 1 | Read strobe for this cycle |
| busAddr | input | 24 | Word address |
| busWrData | input | DataW | Write data; the A operand on triggers |
| busRdData | output | DataW | Read data, one cycle after the read |
| busRdValid | output | 1 | High when busRdData holds an accepted read |

## Verification
Assertions check several properties every cycle:
- Busy follows an accepted trigger by exactly one cycle.
- Scalars hold while no operation is retiring and no store targets them.
- The mode and index registers move only on their own addresses, and the index steps by one on the incrementing trigger.
- A collapse clears the upper scalars.
- Reads of foreign or broadcast addresses stay silent.

The arithmetic of each form, the mirror variants, the broadcast fan-out to a second instance, the index wrap and the equivalence of back-to-back triggers with sequential execution can only be shown by the bench. It compares read-back storage with a reference model after directed and random operation sequences.

// File: rtl/mvp_pkg.sv
`timescale 1ns/1ps
package mvp_pkg;
  localparam int NumVec  = 8;
  localparam int HalfVec = NumVec / 2;

  typedef enum logic [1:0] {
    FORM_DOT  = 2'd0,
    FORM_VACC = 2'd1,
    FORM_VMSA = 2'd2,
    FORM_NONE = 2'd3
  } form_e;

  localparam logic [15:0] OFF_SCL     = 16'h8000;
  localparam logic [15:0] OFF_MODE    = 16'h8010;
  localparam logic [15:0] OFF_IDX     = 16'h8011;
  localparam logic [15:0] OFF_STAT    = 16'h8012;
  localparam logic [15:0] OFF_TRIG    = 16'h8020;
  localparam logic [15:0] OFF_TRIGINC = 16'h8021;
  localparam logic [15:0] OFF_COLL    = 16'h8022;

  typedef struct packed {
    logic  fire;
    logic  collapse;
    form_e form;
    logic  mirror;
    logic  vecStore;
    logic  sclStore;
  } strobes_t;
endpackage

// File: rtl/mvp_ctrl.sv
`timescale 1ns/1ps
module mvp_ctrl
  import mvp_pkg::*;
#(
  parameter int         DataW   = 32,
  parameter int         IdxBits = 8,
  parameter logic [3:0] ModId   = 4'd0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [23:0]        busAddr,
  input  logic [DataW-1:0]   busWrData,
  input  logic [DataW-1:0]   vecRdData,
  input  logic [DataW-1:0]   sclRdData,
  input  logic               busy,
  output strobes_t           strb,
  output logic [IdxBits-1:0] opIdx,
  output logic [IdxBits-1:0] elemIdx,
  output logic [2:0]         vecSel,
  output logic [2:0]         sclSel,
  output logic [DataW-1:0]   busRdData,
  output logic               busRdValid
);
  localparam logic [3:0] BcastSeg = 4'hF;

  logic [15:0]        off;
  logic [3:0]         seg;
  logic               inTop, ownSeg, bcastSeg, wrHit, rdHit;
  logic               isVec, isScl;
  logic [2:0]         modeReg;
  logic [IdxBits-1:0] idxReg;
  logic [DataW-1:0]   rdMux;

  assign off      = busAddr[15:0];
  assign seg      = busAddr[19:16];
  assign inTop    = (busAddr[23:20] == 4'hF);
  assign ownSeg   = inTop && (seg == ModId);
  assign bcastSeg = inTop && (seg == BcastSeg);
  assign wrHit    = busWrEn && (ownSeg || bcastSeg);
  assign rdHit    = busRdEn && ownSeg;
  assign isVec    = (off[15] == 1'b0);
  assign isScl    = (off[15:3] == OFF_SCL[15:3]);

  assign elemIdx = off[IdxBits-1:0];
  assign vecSel  = off[14:12];
  assign sclSel  = off[2:0];
  assign opIdx   = idxReg;

  always_comb begin
    strb.fire     = wrHit && (off == OFF_TRIG || off == OFF_TRIGINC || off == OFF_COLL);
    strb.collapse = (off == OFF_COLL);
    strb.form     = form_e'(modeReg[1:0]);
    strb.mirror   = modeReg[2];
    strb.vecStore = wrHit && isVec;
    strb.sclStore = wrHit && isScl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      idxReg  <= '0;
    end else if (wrHit) begin
      if (off == OFF_MODE) modeReg <= busWrData[2:0];
      if (off == OFF_IDX) idxReg <= busWrData[IdxBits-1:0];
      else if (off == OFF_TRIGINC) idxReg <= idxReg + IdxBits'(1);
    end
  end

  always_comb begin
    rdMux = '0;
    if (isVec) rdMux = vecRdData;
    else if (isScl) rdMux = sclRdData;
    else if (off == OFF_MODE) rdMux[2:0] = modeReg;
    else if (off == OFF_IDX) rdMux[IdxBits-1:0] = idxReg;
    else if (off == OFF_STAT) rdMux[0] = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdValid <= 1'b0;
      busRdData  <= '0;
    end else begin
      busRdValid <= rdHit;
      busRdData  <= rdHit ? rdMux : '0;
    end
  end

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && off == OFF_TRIGINC) |=> idxReg == IdxBits'($past(idxReg) + 1'b1));

  assert_index_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHit && (off == OFF_IDX || off == OFF_TRIGINC)) |=> $stable(idxReg));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHit && off == OFF_MODE) |=> $stable(modeReg));

  assert_silent_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !ownSeg) |=> (!busRdValid && busRdData == '0));
endmodule

// File: rtl/mvp_datapath.sv
`timescale 1ns/1ps
module mvp_datapath
  import mvp_pkg::*;
#(
  parameter int DataW   = 32,
  parameter int IdxBits = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DataW-1:0]   opData,
  input  logic [IdxBits-1:0] opIdx,
  input  logic [IdxBits-1:0] elemIdx,
  input  logic [2:0]         vecSel,
  input  logic [2:0]         sclSel,
  output logic [DataW-1:0]   vecRdData,
  output logic [DataW-1:0]   sclRdData,
  output logic               busy
);
  localparam int Depth = 1 << IdxBits;

  logic [DataW-1:0]   sclReg [NumVec];
  logic [DataW-1:0]   vAtOp  [NumVec];
  logic [DataW-1:0]   vAtS2  [NumVec];
  logic [DataW-1:0]   vAtRd  [NumVec];
  logic [DataW-1:0]   fwdV   [NumVec];
  logic [DataW-1:0]   fwdS   [NumVec];
  logic [DataW-1:0]   mulSrc [NumVec];
  logic [DataW-1:0]   s2Prod [NumVec];
  logic [DataW-1:0]   sum    [NumVec];
  logic [DataW-1:0]   wVal   [NumVec];
  logic [DataW-1:0]   wSVal  [NumVec];
  logic [NumVec-1:0]  wVEn, wSEn;
  logic [DataW-1:0]   total;

  logic               s2Valid, s2Collapse, s2Mirror;
  form_e              s2Form;
  logic [IdxBits-1:0] s2Idx;

  // Vector register file: one memory per register, op write then host store (host wins on same element)
  for (genvar r = 0; r < NumVec; r++) begin : g_vec
    logic [DataW-1:0] mem [Depth];
    always_ff @(posedge clk) begin
      if (wVEn[r]) mem[s2Idx] <= wVal[r];
      if (strb.vecStore && vecSel == 3'(r)) mem[elemIdx] <= opData;
    end
    assign vAtOp[r] = mem[opIdx];
    assign vAtS2[r] = mem[s2Idx];
    assign vAtRd[r] = mem[elemIdx];
  end

  assign vecRdData = vAtRd[vecSel];
  assign sclRdData = sclReg[sclSel];
  assign busy      = s2Valid;

  // Stage 1: multiplier operand select with forwarding from the retiring stage
  always_comb begin
    for (int k = 0; k < NumVec; k++) begin
      fwdV[k] = (wVEn[k] && s2Idx == opIdx) ? wVal[k] : vAtOp[k];
      fwdS[k] = wSEn[k] ? wSVal[k] : sclReg[k];
    end
    for (int k = 0; k < NumVec; k++) begin
      mulSrc[k] = '0;
      case (strb.form)
        FORM_DOT:  mulSrc[k] = fwdV[k];
        FORM_VACC: if (k < HalfVec) mulSrc[k] = fwdS[k];
        FORM_VMSA: if (k < HalfVec) mulSrc[k] = strb.mirror ? fwdV[k+HalfVec] : fwdV[k];
        default:   mulSrc[k] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid    <= 1'b0;
      s2Collapse <= 1'b0;
      s2Mirror   <= 1'b0;
      s2Form     <= FORM_DOT;
      s2Idx      <= '0;
    end else begin
      s2Valid    <= strb.fire;
      s2Collapse <= strb.collapse;
      s2Mirror   <= strb.mirror;
      s2Form     <= strb.form;
      s2Idx      <= opIdx;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NumVec; k++) s2Prod[k] <= opData * mulSrc[k];
  end

  // Stage 2: adder and write-back
  always_comb begin
    total = '0;
    for (int k = 0; k < NumVec; k++) total = total + sclReg[k];
    for (int k = 0; k < NumVec; k++) begin
      if (k < HalfVec && s2Form == FORM_VACC)
        sum[k] = s2Prod[k] + (s2Mirror ? vAtS2[k+HalfVec] : vAtS2[k]);
      else
        sum[k] = s2Prod[k] + sclReg[k];
    end
    for (int r = 0; r < NumVec; r++) begin
      wVEn[r]  = s2Valid && !s2Collapse && (s2Form == FORM_VACC || s2Form == FORM_VMSA)
                 && ((r >= HalfVec) != s2Mirror);
      wVal[r]  = sum[r % HalfVec];
      wSEn[r]  = s2Valid && (s2Collapse || s2Form == FORM_DOT);
      wSVal[r] = s2Collapse ? ((r == 0) ? total : '0) : sum[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NumVec; k++) sclReg[k] <= '0;
    end else begin
      for (int k = 0; k < NumVec; k++) begin
        if (strb.sclStore && sclSel == 3'(k)) sclReg[k] <= opData;
        else if (wSEn[k]) sclReg[k] <= wSVal[k];
      end
    end
  end

  assert_busy_after_fire_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> busy);

  assert_idle_after_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> !busy);

  assert_collapse_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && s2Collapse && !(strb.sclStore && sclSel == 3'd1)) |=> sclReg[1] == '0);

  for (genvar k = 0; k < NumVec; k++) begin : g_sclChk
    assert_scalar_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!busy && !strb.sclStore) |=> $stable(sclReg[k]));
  end
endmodule

// File: rtl/bcast_mac_node.sv
`timescale 1ns/1ps
module bcast_mac_node
  import mvp_pkg::*;
#(
  parameter int         DataW   = 32,
  parameter int         IdxBits = 8,
  parameter logic [3:0] ModId   = 4'd0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [23:0]      busAddr,
  input  logic [DataW-1:0] busWrData,
  output logic [DataW-1:0] busRdData,
  output logic             busRdValid
);
  strobes_t           strb;
  logic [IdxBits-1:0] opIdx, elemIdx;
  logic [2:0]         vecSel, sclSel;
  logic [DataW-1:0]   vecRdData, sclRdData;
  logic               busy;

  mvp_ctrl #(.DataW(DataW), .IdxBits(IdxBits), .ModId(ModId)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .vecRdData(vecRdData),
    .sclRdData(sclRdData), .busy(busy), .strb(strb), .opIdx(opIdx),
    .elemIdx(elemIdx), .vecSel(vecSel), .sclSel(sclSel),
    .busRdData(busRdData), .busRdValid(busRdValid)
  );

  mvp_datapath #(.DataW(DataW), .IdxBits(IdxBits)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opData(busWrData), .opIdx(opIdx),
    .elemIdx(elemIdx), .vecSel(vecSel), .sclSel(sclSel),
    .vecRdData(vecRdData), .sclRdData(sclRdData), .busy(busy)
  );
endmodule

// File: tb/test_bcast_mac_node.sv
`timescale 1ns/1ps
module test_bcast_mac_node;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [23:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData, peerRdData;
  logic        busRdValid, peerRdValid;

  int tests = 0, fails = 0;

  logic [31:0] refV [8][256];
  logic [31:0] refS [8];
  logic [2:0]  refMode = '0;
  logic [7:0]  refIdx = '0;
  logic [31:0] rData, pData;
  logic        rValid, pValid;

  always #2.5 clk = ~clk;

  bcast_mac_node #(.DataW(32), .IdxBits(8), .ModId(4'd0)) i_bcast_mac_node (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busRdValid(busRdValid));

  bcast_mac_node #(.DataW(32), .IdxBits(8), .ModId(4'd1)) i_bcast_mac_node_peer (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(peerRdData), .busRdValid(peerRdValid));

  function automatic logic [23:0] own(input logic [15:0] off);
    return {4'hF, 4'h0, off};
  endfunction
  function automatic logic [23:0] bc(input logic [15:0] off);
    return {4'hF, 4'hF, off};
  endfunction
  function automatic logic [15:0] vOff(input int r, input int e);
    return 16'((r << 12) | e);
  endfunction

  function automatic void mOp(input logic [31:0] a);
    logic [1:0] f = refMode[1:0];
    logic       m = refMode[2];
    int         i = refIdx;
    case (f)
      2'd0: for (int k = 0; k < 8; k++) refS[k] = a * refV[k][i] + refS[k];
      2'd1: for (int k = 0; k < 4; k++)
              if (!m) refV[4+k][i] = a * refS[k] + refV[k][i];
              else    refV[k][i]   = a * refS[k] + refV[4+k][i];
      2'd2: for (int k = 0; k < 4; k++)
              if (!m) refV[4+k][i] = a * refV[k][i] + refS[k];
              else    refV[k][i]   = a * refV[4+k][i] + refS[k];
      default: ;
    endcase
  endfunction

  function automatic void mCollapse();
    logic [31:0] t = '0;
    for (int k = 0; k < 8; k++) t = t + refS[k];
    refS[0] = t;
    for (int k = 1; k < 8; k++) refS[k] = '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    rData = busRdData; rValid = busRdValid;
    pData = peerRdData; pValid = peerRdValid;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic setMode(input logic [2:0] m);
    wr(own(16'h8010), {29'd0, m}); refMode = m;
  endtask
  task automatic setIdx(input logic [7:0] i);
    wr(own(16'h8011), {24'd0, i}); refIdx = i;
  endtask
  task automatic trig(input logic [31:0] a);
    wr(own(16'h8020), a); mOp(a);
  endtask
  task automatic trigInc(input logic [31:0] a);
    wr(own(16'h8021), a); mOp(a); refIdx = refIdx + 8'd1;
  endtask
  task automatic collapse();
    wr(own(16'h8022), 32'd0); mCollapse();
  endtask
  task automatic storeS(input int k, input logic [31:0] d);
    wr(own(16'h8000 + 16'(k)), d); refS[k] = d;
  endtask
  task automatic storeV(input int r, input int e, input logic [31:0] d);
    wr(own(vOff(r, e)), d); refV[r][e] = d;
  endtask

  task automatic checkAllS(input string req);
    for (int k = 0; k < 8; k++) begin
      rd(own(16'h8000 + 16'(k)));
      check(req, rData, refS[k]);
    end
  endtask
  task automatic checkV(input string req, input int r, input int e);
    rd(own(vOff(r, e)));
    check(req, rData, refV[r][e]);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seedSink;
    seedSink = $urandom(32'd1234);
    for (int k = 0; k < 8; k++) refS[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();

    // R13 reset state
    checkAllS("R13 scalar reset");
    rd(own(16'h8010)); check("R13 mode reset", rData, 32'd0);
    rd(own(16'h8011)); check("R13 index reset", rData, 32'd0);
    rd(own(16'h8012)); check("R13 busy reset", rData, 32'd0);

    // R3 preload and readback
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 16; e++) storeV(r, e, $urandom % 1000);
    for (int k = 0; k < 8; k++) storeS(k, $urandom % 1000);
    checkV("R3 vector store", 3, 5);
    checkV("R3 vector store", 7, 15);
    rd(own(16'h8002)); check("R3 scalar store", rData, refS[2]);
    rd(own(16'h8000)); check("R2 own read valid", {31'd0, rValid}, 32'd1);

    // R4 scalar accumulation and R9 busy
    setMode(3'd0); setIdx(8'd2);
    rd(own(16'h8010)); check("R3 mode readback", rData, 32'd0);
    rd(own(16'h8011)); check("R3 index readback", rData, 32'd2);
    trig(32'd3);
    rd(own(16'h8012)); check("R9 busy after trigger", rData, 32'd1);
    rd(own(16'h8012)); check("R9 busy cleared", rData, 32'd0);
    checkAllS("R4 dot form");

    // R5 vector accumulation, both halves
    setMode(3'd1); setIdx(8'd4); trig(32'd7); idle();
    for (int r = 4; r < 8; r++) checkV("R5 vacc mirror0", r, 4);
    setMode(3'd5); trig(32'd11); idle();
    for (int r = 0; r < 4; r++) checkV("R5 vacc mirror1", r, 4);

    // R6 vector multiply / scalar add, both halves
    setMode(3'd2); setIdx(8'd6); trig(32'd5); idle();
    for (int r = 4; r < 8; r++) checkV("R6 vmsa mirror0", r, 6);
    setMode(3'd6); trig(32'd9); idle();
    for (int r = 0; r < 4; r++) checkV("R6 vmsa mirror1", r, 6);

    // R7 post-increment and wrap; R11 form 3 no effect
    setMode(3'd0); setIdx(8'd7); trigInc(32'd2); idle();
    rd(own(16'h8011)); check("R7 index increment", rData, 32'd8);
    trig(32'd1); idle();
    rd(own(16'h8011)); check("R7 plain trigger keeps index", rData, 32'd8);
    checkAllS("R7 dot after increment");
    setMode(3'd3); setIdx(8'd255); trigInc(32'd99); idle();
    rd(own(16'h8011)); check("R7 index wrap", rData, 32'd0);
    setIdx(8'd1); trig(32'd77); idle();
    checkAllS("R11 form3 scalars");
    for (int r = 0; r < 8; r++) checkV("R11 form3 vectors", r, 1);

    // R8 collapse
    collapse(); idle();
    checkAllS("R8 collapse");

    // R12 wrap-around arithmetic
    storeV(0, 9, 32'h8000_0000); storeS(0, 32'hFFFF_FFFF);
    setMode(3'd0); setIdx(8'd9); trig(32'd2); idle();
    rd(own(16'h8000)); check("R12 modular sum", rData, 32'hFFFF_FFFF);
    checkAllS("R12 dot wrap");

    // R1 / R2 broadcast and decode
    wr(bc(16'h8005), 32'h1234); refS[5] = 32'h1234;
    rd(own(16'h8005)); check("R1 broadcast main", rData, 32'h1234);
    rd({4'hF, 4'h1, 16'h8005}); check("R1 broadcast peer", pData, 32'h1234);
    wr(own(16'h8006), 32'h55); refS[6] = 32'h55;
    rd({4'hF, 4'h1, 16'h8006}); check("R1 peer ignores foreign segment", pData, 32'd0);
    wr({4'h7, 4'h0, 16'h8005}, 32'hDEAD);
    rd(own(16'h8005)); check("R1 outside top megaword ignored", rData, 32'h1234);
    rd(bc(16'h8005));
    check("R2 broadcast read valid", {31'd0, rValid}, 32'd0);
    check("R2 broadcast read data", rData, 32'd0);

    // R10 random back-to-back operation stream
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 10;
      case (sel)
        0: setMode(3'($urandom % 8));
        1: setIdx(8'($urandom % 16));
        2, 3, 4: trig($urandom);
        5, 6: if (refIdx < 8'd15) trigInc($urandom); else trig($urandom);
        7: collapse();
        8: storeS($urandom % 8, $urandom);
        default: storeV($urandom % 8, $urandom % 16, $urandom);
      endcase
    end
    idle();
    checkAllS("R10 random scalars");
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 16; e++) checkV("R10 random vectors", r, e);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule